// File: doc/BRIEF.md
# Timer Capture/Compare Interrupt Flag Unit

This block holds the event flags and interrupt masking for one channel of a multi-channel 16-bit timer. The channel's counter, its two general registers (A and B), the prescaler, the pin logic and the DMA controller live elsewhere. They reach this block only as single-cycle strobes: a compare match per general register, a capture edge per general register, a counter wrap, and a DMA acknowledge.

Three flags are kept. Flag A is bit 0, flag B is bit 1 and the overflow flag is bit 2. Each general register has a mode input that picks which strobe sets its flag: the match strobe in compare mode, the capture strobe in capture mode. Software clears a flag in two steps. It reads the status register while the flag is 1, and it later writes 0 to that bit. On channels built with the DMA path enabled, a DMA acknowledge also clears flag A. An 8-bit enable register gates each flag onto its interrupt request output. Its upper five bits are fixed per channel by a parameter.

Reset and standby entry both return the flags, the read markers and the enable register to their initial values.

Top module: `tmr_flag_unit`

## Requirements
- R1: With a general register in compare mode (its mode bit 0), its match strobe sets its flag (A = status bit 0, B = status bit 1) on the next clock edge, and its capture strobe has no effect.
- R2: With a general register in capture mode (its mode bit 1), its capture strobe sets its flag on the next clock edge, and its match strobe has no effect.
- R3: The counter-wrap strobe sets the overflow flag, which is status bit 2.
- R4: A status read records, for each bit, whether the flag was 1. A later status write with 0 in a bit clears that flag only if the most recent read saw it at 1 and the flag has stayed set since that read. A status write of 1 to a bit, or a write of 0 with no such read, leaves the flag unchanged. Any status write consumes all the markers.
- R5: When a set event and a clear (software or DMA) hit the same flag in the same cycle, the flag ends up set.
- R6: When DMA_CLR_EN is 1, the DMA acknowledge clears flag A. When DMA_CLR_EN is 0, the DMA acknowledge has no effect.
- R7: The enable register reads back as {IER_RST[7:3], en[2:0]}. A write updates only bits 2:0: bit 0 enables A, bit 1 enables B and bit 2 enables overflow. After reset, en is IER_RST[2:0].
- R8: Each interrupt request output is high exactly while its flag and its enable bit are both 1.
- R9: While standby is high, the flags and markers are held at 0 and the enable register is held at its reset value. Standby has priority over set events and over writes.
- R10: After reset the status register reads 8'hF8 (upper bits read as 1, all flags 0) and all interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| standby_i | input | 1 | Standby entry; reinitialises all state while high |
| gr_mode_i | input | 2 | Per general register mode ([0]=A, [1]=B); 0 compare, 1 capture |
| gr_match_i | input | 2 | Counter-equals-register strobes ([0]=A, [1]=B) |
| gr_capt_i | input | 2 | Capture transfer strobes ([0]=A, [1]=B) |
| ovf_i | input | 1 | Counter wrap strobe (0xFFFF to 0x0000) |
| dma_ack_i | input | 1 | DMA activated by the flag-A request |
| sts_rd_i | input | 1 | Status register read strobe |
| sts_wr_i | input | 1 | Status register write strobe |
| ier_wr_i | input | 1 | Enable register write strobe |
| wdata_i | input | 8 | Write data for both registers |
| sts_rdata_o | output | 8 | Status register read value |
| ier_rdata_o | output | 8 | Enable register read value |
| irq_a_o | output | 1 | Interrupt request for flag A |
| irq_b_o | output | 1 | Interrupt request for flag B |
| irq_ovf_o | output | 1 | Interrupt request for overflow |

## Verification
The case that is hardest to reach is a stale marker. A flag is read at 1, cleared by DMA, set again by a new event, and then written with 0. A correct design keeps the new event, so the clear must not apply. A collision between a set strobe and a clear in the same cycle is similarly hard to reach. Directed sequences build both cases step by step. Long random runs then mix reads, writes, DMA acknowledges and strobes, so that read-write gaps of many lengths occur with events landing between them. Two instances share all stimulus, one with the DMA path enabled and one without, so every DMA acknowledge is checked both ways.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_GR    = 2;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FB_A      = 0;
  localparam int unsigned FB_B      = 1;
  localparam int unsigned FB_OVF    = 2;
  localparam int unsigned PAD_W     = REG_W - NUM_FLAGS;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
  typedef logic [NUM_GR-1:0]    gr_vec_t;
endpackage

// File: rtl/tfu_gr_event.sv
module tfu_gr_event
  import tfu_pkg::*;
#(
  parameter int unsigned NGR = NUM_GR
) (
  input  logic [NGR-1:0] mode_i,
  input  logic [NGR-1:0] match_i,
  input  logic [NGR-1:0] capt_i,
  output logic [NGR-1:0] set_o
);
  for (genvar g = 0; g < NGR; g++) begin : g_gr
    always_comb begin
      if (mode_i[g]) set_o[g] = capt_i[g];
      else           set_o[g] = match_i[g];
    end
  end
endmodule

// File: rtl/tfu_flag_bit.sv
module tfu_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_n;
  logic mark_q, mark_n;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_i & mark_q & ~wbit_i;
    if (stby_i) begin
      flag_n = 1'b0;
      mark_n = 1'b0;
    end else begin
      flag_n = set_i | (flag_q & ~(sw_clr | hw_clr_i));
      if (rd_i)      mark_n = flag_q;
      else if (wr_i) mark_n = 1'b0;
      else           mark_n = mark_q & flag_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
      mark_q <= mark_n;
    end
  end

  assign flag_o = flag_q;

  // R5: a set event always leaves the flag at 1
  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !stby_i) |=> flag_q);

  // R4: without a marker, a write cannot clear the flag
  p_no_unmarked_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !mark_q && !hw_clr_i && !stby_i) |=> flag_q);

  // R4: a write of 1 never clears the flag
  p_write_one_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_i && wbit_i && !hw_clr_i && !stby_i) |=> flag_q);
endmodule

// File: rtl/tfu_ier.sv
module tfu_ier
  import tfu_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 8'hF8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output flag_vec_t        en_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam flag_vec_t EN_RST = RST_VAL[NUM_FLAGS-1:0];

  flag_vec_t en_q, en_n;
  logic      en_ce;

  always_comb begin
    en_ce = stby_i | wr_i;
    if (stby_i) en_n = EN_RST;
    else        en_n = wdata_i[NUM_FLAGS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= EN_RST;
    else if (en_ce) en_q <= en_n;
  end

  assign en_o    = en_q;
  assign rdata_o = {RST_VAL[REG_W-1:NUM_FLAGS], en_q};

  // R7: enables move only on a write or standby
  p_ier_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !stby_i) |=> $stable(en_q));

  // R9: standby restores the reset enables
  p_ier_standby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (en_q == EN_RST));
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tfu_pkg::*;
#(
  parameter bit               DMA_CLR_EN = 1'b1,
  parameter logic [REG_W-1:0] IER_RST    = 8'hF8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic [NUM_GR-1:0] gr_mode_i,
  input  logic [NUM_GR-1:0] gr_match_i,
  input  logic [NUM_GR-1:0] gr_capt_i,
  input  logic             ovf_i,
  input  logic             dma_ack_i,
  input  logic             sts_rd_i,
  input  logic             sts_wr_i,
  input  logic             ier_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_rdata_o,
  output logic [REG_W-1:0] ier_rdata_o,
  output logic             irq_a_o,
  output logic             irq_b_o,
  output logic             irq_ovf_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gr_vec_t   gr_set;
  flag_vec_t set_vec, hwclr_vec, flags, en;

  tfu_gr_event #(.NGR(NUM_GR)) u_gr_event (
    .mode_i  (gr_mode_i),
    .match_i (gr_match_i),
    .capt_i  (gr_capt_i),
    .set_o   (gr_set)
  );

  always_comb begin
    set_vec         = '0;
    hwclr_vec       = '0;
    set_vec[FB_A]   = gr_set[0];
    set_vec[FB_B]   = gr_set[1];
    set_vec[FB_OVF] = ovf_i;
    hwclr_vec[FB_A] = DMA_CLR_EN & dma_ack_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    tfu_flag_bit u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_int_n),
      .stby_i   (standby_i),
      .set_i    (set_vec[i]),
      .hw_clr_i (hwclr_vec[i]),
      .rd_i     (sts_rd_i),
      .wr_i     (sts_wr_i),
      .wbit_i   (wdata_i[i]),
      .flag_o   (flags[i])
    );
  end

  tfu_ier #(.RST_VAL(IER_RST)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .stby_i  (standby_i),
    .wr_i    (ier_wr_i),
    .wdata_i (wdata_i),
    .en_o    (en),
    .rdata_o (ier_rdata_o)
  );

  assign sts_rdata_o = {{PAD_W{1'b1}}, flags};
  assign irq_a_o     = flags[FB_A]   & en[FB_A];
  assign irq_b_o     = flags[FB_B]   & en[FB_B];
  assign irq_ovf_o   = flags[FB_OVF] & en[FB_OVF];

  // R2: capture strobe in capture mode raises flag A
  p_capture_sets_a_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (gr_mode_i[0] && gr_capt_i[0] && !standby_i) |=> sts_rdata_o[FB_A]);

  // R3: counter wrap raises the overflow flag
  p_wrap_sets_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (ovf_i && !standby_i) |=> sts_rdata_o[FB_OVF]);

  // R6: DMA acknowledge clears flag A on channels that have the path
  p_dma_clears_a_r6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (DMA_CLR_EN && dma_ack_i && !gr_set[0]) |=> !sts_rdata_o[FB_A]);

  // R9: standby empties all flags and drops the requests
  p_standby_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    standby_i |=> (sts_rdata_o[NUM_FLAGS-1:0] == '0 && !irq_a_o && !irq_b_o && !irq_ovf_o));
endmodule

// File: tb/tmr_flag_unit_tb_top.sv
module tmr_flag_unit_tb_top;
  localparam logic [7:0] RST0 = 8'hF8;
  localparam logic [7:0] RST1 = 8'h78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0, ovf = 1'b0, dma = 1'b0, rd = 1'b0, wr = 1'b0, iwr = 1'b0;
  logic [1:0] mode = 2'b00, match = 2'b00, capt = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] sts0, ier0, sts1, ier1;
  logic ia0, ib0, io0, ia1, ib1, io1;

  int n_chk = 0;
  int n_bad = 0;

  // model state, index 0 = DMA path on, 1 = off
  logic [2:0] m_f [2];
  logic [2:0] m_k [2];
  logic [2:0] m_e [2];

  always #2ns clk = ~clk;

  tmr_flag_unit #(.DMA_CLR_EN(1'b1), .IER_RST(RST0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .gr_mode_i(mode),
    .gr_match_i(match), .gr_capt_i(capt), .ovf_i(ovf), .dma_ack_i(dma),
    .sts_rd_i(rd), .sts_wr_i(wr), .ier_wr_i(iwr), .wdata_i(wdata),
    .sts_rdata_o(sts0), .ier_rdata_o(ier0), .irq_a_o(ia0), .irq_b_o(ib0), .irq_ovf_o(io0));

  tmr_flag_unit #(.DMA_CLR_EN(1'b0), .IER_RST(RST1)) dut_nodma_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .gr_mode_i(mode),
    .gr_match_i(match), .gr_capt_i(capt), .ovf_i(ovf), .dma_ack_i(dma),
    .sts_rd_i(rd), .sts_wr_i(wr), .ier_wr_i(iwr), .wdata_i(wdata),
    .sts_rdata_o(sts1), .ier_rdata_o(ier1), .irq_a_o(ia1), .irq_b_o(ib1), .irq_ovf_o(io1));

  function automatic logic [2:0] set_events();
    logic [2:0] s;
    s[0] = mode[0] ? capt[0] : match[0];  // R1 R2
    s[1] = mode[1] ? capt[1] : match[1];
    s[2] = ovf;                           // R3
    return s;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_f[c] = 3'b000;
      m_k[c] = 3'b000;
      m_e[c] = (c == 0) ? RST0[2:0] : RST1[2:0];
    end
  endtask

  task automatic model_step();
    logic [2:0] s, clr, nk;
    s = set_events();
    for (int c = 0; c < 2; c++) begin
      if (standby) begin                                       // R9
        m_f[c] = 3'b000;
        m_k[c] = 3'b000;
        m_e[c] = (c == 0) ? RST0[2:0] : RST1[2:0];
      end else begin
        clr = (wr ? (m_k[c] & ~wdata[2:0]) : 3'b000);          // R4
        if (c == 0 && dma) clr[0] = 1'b1;                      // R6
        if (rd)      nk = m_f[c];
        else if (wr) nk = 3'b000;
        else         nk = m_k[c] & m_f[c];
        m_f[c] = s | (m_f[c] & ~clr);                          // R5
        m_k[c] = nk;
        if (iwr) m_e[c] = wdata[2:0];                          // R7
      end
    end
  endtask

  task automatic cmp8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic check(string tag);
    cmp8(tag, "status ch0", sts0, {5'b11111, m_f[0]});
    cmp8(tag, "status ch1", sts1, {5'b11111, m_f[1]});
    cmp8(tag, "enable ch0", ier0, {RST0[7:3], m_e[0]});
    cmp8(tag, "enable ch1", ier1, {RST1[7:3], m_e[1]});
    cmp8(tag, "irq ch0 (R8)", {5'b0, io0, ib0, ia0}, {5'b0, m_f[0] & m_e[0]});
    cmp8(tag, "irq ch1 (R8)", {5'b0, io1, ib1, ia1}, {5'b0, m_f[1] & m_e[1]});
  endtask

  task automatic idle();
    standby = 0; ovf = 0; dma = 0; rd = 0; wr = 0; iwr = 0;
    match = 2'b00; capt = 2'b00; wdata = 8'h00;
  endtask

  // one clock with the currently driven inputs, then compare
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    idle();
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 R7 reset");

    // R1: compare mode, match sets A, capture ignored on B
    mode = 2'b00; match[0] = 1'b1; cyc("R1 match A");
    capt[1] = 1'b1;                cyc("R1 capture ignored");
    // R2: capture mode on B, match ignored then capture sets
    mode = 2'b10; match[1] = 1'b1; cyc("R2 match ignored");
    mode = 2'b10; capt[1] = 1'b1;  cyc("R2 capture B");
    // R3: wrap
    ovf = 1'b1;                    cyc("R3 overflow");
    // R4: write 0 with no earlier read, then write 1 after read
    wr = 1'b1; wdata = 8'h00;      cyc("R4 write without read");
    rd = 1'b1;                     cyc("R4 read");
    wr = 1'b1; wdata = 8'hFF;      cyc("R4 write one");
    rd = 1'b1;                     cyc("R4 read again");
    wr = 1'b1; wdata = 8'hFE;      cyc("R4 clear A only");
    // R8: enable all
    iwr = 1'b1; wdata = 8'h07;     cyc("R7 R8 enable write");
    // R5: set collides with clear
    rd = 1'b1;                     cyc("R5 read");
    wr = 1'b1; wdata = 8'h00; match[0] = 1'b0; ovf = 1'b1; cyc("R5 ovf vs clear");
    // R6: DMA ack on A in both channels
    mode = 2'b00; match[0] = 1'b1; cyc("R6 arm A");
    dma = 1'b1;                    cyc("R6 dma ack");
    // stale marker: read A at 1, DMA clears, new set, then write 0
    mode = 2'b00; match[0] = 1'b1; cyc("R4 rearm");
    rd = 1'b1;                     cyc("R4 read A");
    dma = 1'b1;                    cyc("R6 dma after read");
    match[0] = 1'b1;               cyc("R4 new event");
    wr = 1'b1; wdata = 8'h00;      cyc("R4 stale marker write");
    // R5: DMA and set in the same cycle
    dma = 1'b1; match[0] = 1'b1;   cyc("R5 dma vs set");
    // R9: standby overrides set and writes
    standby = 1'b1; ovf = 1'b1; iwr = 1'b1; wdata = 8'h05; cyc("R9 standby");
    cyc("R9 after standby");

    for (int i = 0; i < 4000; i++) begin
      mode    = (($urandom_range(0, 15) == 0) ? 2'($urandom) : mode);
      match   = 2'($urandom) & 2'($urandom);
      capt    = 2'($urandom) & 2'($urandom);
      ovf     = ($urandom_range(0, 4) == 0);
      dma     = ($urandom_range(0, 7) == 0);
      rd      = ($urandom_range(0, 2) == 0);
      wr      = ($urandom_range(0, 2) == 0);
      iwr     = ($urandom_range(0, 15) == 0);
      standby = ($urandom_range(0, 99) == 0);
      wdata   = 8'($urandom);
      cyc("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule